// File: doc/BRIEF.md
# Asynchronous SRAM Controller

This block sits on the synchronous side of a chip and runs single-word accesses to an external asynchronous static RAM, 16 bits wide. A user agent offers a request (address, write data, a two-bit lane mask and a write flag) under a valid/ready handshake. The controller then plays out a timed sequence of chip-select, output-enable, write-enable and byte-lane strobes on the memory pins. Read data comes back on a one-clock response pulse. Writes return nothing beyond the handshake.

Each phase of the sequence lasts a whole number of clocks. That number is worked out at elaboration from the memory's timing limits, given in picoseconds, and a clock-period parameter. Every count is rounded up and is never less than one clock. The data bus is split into an input, an output and a driver-enable, so the tristate buffer can live at the pad. Before its drivers turn on, the controller leaves time for the memory to let go of the bus after a read.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is low, and after it is released with no request, both chip selects are inactive (`mem_sel_n`=1, `mem_sel_p`=0), `mem_outen_n`=1, `mem_wren_n`=1, both lane enables are high, `mem_dq_oe`=0, `rsp_valid`=0 and `req_ready`=1.
- R2: `mem_sel_n` is always the inverse of `mem_sel_p`. The memory counts as selected only when `mem_sel_n`=0 and `mem_sel_p`=1.
- R3: A read drives both lane enables and the output enable low. The returned word is the one the memory drives. `rsp_valid` is high for exactly one clock, ceil(max(55 ns, 25 ns)/Tclk) clocks after the accepting edge. The output enable is never low while the lane enables are not both low.
- R4: The chip-select assertion of one access starts at least 55 ns after that of the previous one, and the address does not change while the chip is selected.
- R5: During a write, write enable is low only while the chip is selected and at least one lane enable is low. The low pulse lasts at least 40 ns. When write enable rises, the chip has been selected and the address stable for at least 40 ns, the lane enables low for at least 45 ns, and the data driven for at least 25 ns. The rising edge of write enable ends the write, with the selects and lane enables still asserted.
- R6: Mask bit 0 drives `mem_blo_n` (low byte, data bits 7:0). Mask bit 1 drives `mem_bhi_n` (high byte, bits 15:8). Both are active low, and only the enabled lanes of the stored word change.
- R7: A write with mask 2'b00 is accepted and completes at once. It selects no chip, pulses no write enable and leaves `req_ready` high on the next clock.
- R8: Output enable stays high for the whole of a write. `mem_dq_oe` is high only while output enable is high and has been high for at least 20 ns.
- R9: `req_ready` is high exactly when no access is in progress, which is exactly when the chip is deselected. A request is taken only on a clock where both `req_valid` and `req_ready` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane mask, bit 0 low byte, bit 1 high byte |
| rsp_valid | output | 1 | One-clock pulse with read data |
| rsp_rdata | output | 16 | Read data |
| mem_addr | output | ADDR_W | Memory address |
| mem_sel_n | output | 1 | Chip select, active low |
| mem_sel_p | output | 1 | Chip select, active high |
| mem_outen_n | output | 1 | Memory output enable, active low |
| mem_wren_n | output | 1 | Memory write enable, active low |
| mem_blo_n | output | 1 | Low-byte lane enable, active low |
| mem_bhi_n | output | 1 | High-byte lane enable, active low |
| mem_dq_out | output | 16 | Data to drive onto the bus |
| mem_dq_oe | output | 1 | Pad driver enable for `mem_dq_out` |
| mem_dq_in | input | 16 | Data sampled from the bus |

## Verification
The assertions assume that reset is held for at least one clock. They also assume that the request fields stay stable from the clock `req_valid` rises until the clock the request is taken, and that `mem_dq_in` is only sampled as the sequencer directs. The bench drives its inputs on the falling edge and holds each request until it sees `req_ready`. It models the memory to the nanosecond: reads return a corrupted word until the address, select and output-enable delays have passed, so a read sampled too early is seen as a data error. Addresses come from a 32-word window and masks are drawn at random, so lane merges and write-after-read turnarounds occur many times.

// File: rtl/asram_pkg.sv
`timescale 1ns/1ps
package asram_pkg;

  localparam int DATA_W = 16;
  localparam int LANE_N = 2;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_READ   = 3'd1,
    ST_WSETUP = 3'd2,
    ST_WPULSE = 3'd3,
    ST_WREC   = 3'd4
  } seq_state_e;

  // Whole clocks covering a time, never fewer than one.
  function automatic int clocks_for(input int t_ps, input int clk_ps);
    int n;
    n = (t_ps + clk_ps - 1) / clk_ps;
    if (n < 1) n = 1;
    return n;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Strobe-low time of a read: the later of address access and output-enable
  // access, stretched to the full cycle time.
  function automatic int read_clocks(input int t_acc_ps, input int t_oe_ps,
                                     input int t_cyc_ps, input int clk_ps);
    return imax(clocks_for(imax(t_acc_ps, t_oe_ps), clk_ps),
                clocks_for(t_cyc_ps, clk_ps));
  endfunction

  // Write-enable low clocks: pulse width and data setup alone, and the
  // select/address and lane setups less the clocks already spent in setup.
  function automatic int pulse_clocks(input int t_pw_ps, input int t_ds_ps,
                                      input int t_as_ps, input int t_ls_ps,
                                      input int su_clk, input int clk_ps);
    int n;
    n = imax(clocks_for(t_pw_ps, clk_ps), clocks_for(t_ds_ps, clk_ps));
    n = imax(n, clocks_for(t_as_ps, clk_ps) - su_clk);
    n = imax(n, clocks_for(t_ls_ps, clk_ps) - su_clk);
    return imax(n, 1);
  endfunction

  function automatic int recovery_clocks(input int t_cyc_ps, input int su_clk,
                                         input int pw_clk, input int clk_ps);
    return imax(1, clocks_for(t_cyc_ps, clk_ps) - su_clk - pw_clk);
  endfunction

endpackage

// File: rtl/asram_bus_guard.sv
`timescale 1ns/1ps
module asram_bus_guard #(
  parameter int TURN_CYC = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mem_outen_n,
  input  logic mem_dq_oe,
  output logic bus_free
);
  localparam int QW = $clog2(TURN_CYC + 1) + 1;
  localparam logic [QW-1:0] TURN_Q = QW'(TURN_CYC);

  logic [QW-1:0] quiet_q;

  // Clocks seen with output enable high, saturating at the release time.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      quiet_q <= TURN_Q;
    end else if (!mem_outen_n) begin
      quiet_q <= '0;
    end else if (quiet_q < TURN_Q) begin
      quiet_q <= quiet_q + 1'b1;
    end
  end

  assign bus_free = (quiet_q >= TURN_Q);

  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (mem_outen_n && bus_free)); // R8

endmodule

// File: rtl/asram_rd_path.sv
`timescale 1ns/1ps
module asram_rd_path
  import asram_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_now,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= cap_now;
      if (cap_now) rsp_rdata <= mem_dq_in;
    end
  end

  AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R3

endmodule

// File: rtl/asram_seq.sv
`timescale 1ns/1ps
module asram_seq
  import asram_pkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int RD_CYC  = 14,
  parameter int SU_CYC  = 1,
  parameter int PW_CYC  = 11,
  parameter int REC_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANE_N-1:0] req_mask,
  input  logic              bus_free,
  output logic              req_ready,
  output logic              cap_now,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_sel_n,
  output logic              mem_sel_p,
  output logic              mem_outen_n,
  output logic              mem_wren_n,
  output logic              mem_blo_n,
  output logic              mem_bhi_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe
);
  localparam int CNT_MAX = imax(imax(RD_CYC, PW_CYC), imax(SU_CYC, REC_CYC));
  localparam int CNT_W   = $clog2(CNT_MAX + 1) + 1;
  localparam logic [CNT_W-1:0] RD_LOAD  = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] SU_LOAD  = CNT_W'(SU_CYC - 1);
  localparam logic [CNT_W-1:0] PW_LOAD  = CNT_W'(PW_CYC - 1);
  localparam logic [CNT_W-1:0] REC_LOAD = CNT_W'(REC_CYC - 1);
  localparam logic [CNT_W:0]   LEN_SAT  = {1'b0, {CNT_W{1'b1}}};

  seq_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             cnt_done;
  logic             accept;
  logic             start_rd;
  logic             start_wr;
  logic             selected;
  logic             any_lane;
  logic [CNT_W:0]   we_len_q;

  // Named events, shared by the sequencer and its assertions.
  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign start_rd  = accept && !req_write;
  assign start_wr  = accept && req_write && (req_mask != '0);
  assign cnt_done  = (cnt_q == '0);
  assign cap_now   = (state_q == ST_READ) && cnt_done;
  assign selected  = !mem_sel_n && mem_sel_p;
  assign any_lane  = !(mem_blo_n && mem_bhi_n);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      cnt_q       <= '0;
      mem_addr    <= '0;
      mem_sel_n   <= 1'b1;
      mem_sel_p   <= 1'b0;
      mem_outen_n <= 1'b1;
      mem_wren_n  <= 1'b1;
      mem_blo_n   <= 1'b1;
      mem_bhi_n   <= 1'b1;
      mem_dq_out  <= '0;
      mem_dq_oe   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_rd) begin
            mem_addr    <= req_addr;
            mem_sel_n   <= 1'b0;
            mem_sel_p   <= 1'b1;
            mem_outen_n <= 1'b0;
            mem_blo_n   <= 1'b0;
            mem_bhi_n   <= 1'b0;
            cnt_q       <= RD_LOAD;
            state_q     <= ST_READ;
          end else if (start_wr) begin
            mem_addr   <= req_addr;
            mem_sel_n  <= 1'b0;
            mem_sel_p  <= 1'b1;
            mem_blo_n  <= !req_mask[0];
            mem_bhi_n  <= !req_mask[1];
            mem_dq_out <= req_wdata;
            cnt_q      <= SU_LOAD;
            state_q    <= ST_WSETUP;
          end
        end
        ST_READ: begin
          if (cnt_done) begin
            mem_sel_n   <= 1'b1;
            mem_sel_p   <= 1'b0;
            mem_outen_n <= 1'b1;
            mem_blo_n   <= 1'b1;
            mem_bhi_n   <= 1'b1;
            state_q     <= ST_IDLE;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        ST_WSETUP: begin
          if (bus_free) mem_dq_oe <= 1'b1;
          if (!cnt_done) begin
            cnt_q <= cnt_q - 1'b1;
          end else if (mem_dq_oe) begin
            mem_wren_n <= 1'b0;
            cnt_q      <= PW_LOAD;
            state_q    <= ST_WPULSE;
          end
        end
        ST_WPULSE: begin
          if (cnt_done) begin
            mem_wren_n <= 1'b1;
            cnt_q      <= REC_LOAD;
            state_q    <= ST_WREC;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        ST_WREC: begin
          if (cnt_done) begin
            mem_sel_n <= 1'b1;
            mem_sel_p <= 1'b0;
            mem_blo_n <= 1'b1;
            mem_bhi_n <= 1'b1;
            mem_dq_oe <= 1'b0;
            state_q   <= ST_IDLE;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // Length of the current write-enable low pulse, for the pulse-width check.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      we_len_q <= '0;
    end else if (mem_wren_n) begin
      we_len_q <= '0;
    end else if (we_len_q < LEN_SAT) begin
      we_len_q <= we_len_q + 1'b1;
    end
  end

  AST_SEL_OPPOSITE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_sel_n == !mem_sel_p); // R2
  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !selected); // R9
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (selected && $past(selected)) |-> $stable(mem_addr)); // R4
  AST_READ_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_outen_n |-> (!mem_blo_n && !mem_bhi_n)); // R3
  AST_WE_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_wren_n |-> (selected && any_lane && mem_dq_oe)); // R5
  AST_WE_ENDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_wren_n) |-> (selected && any_lane)); // R5
  AST_WE_PULSE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_wren_n) |-> (we_len_q >= (CNT_W+1)'(PW_CYC))); // R5
  AST_OE_OFF_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_wren_n |-> mem_outen_n); // R8
  AST_EMPTY_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_write && (req_mask == '0)) |=> (req_ready && !selected)); // R7

endmodule

// File: rtl/asram_ctrl.sv
`timescale 1ns/1ps
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int ADDR_W      = 20,
  parameter int CLK_PS      = 4000,
  parameter int T_CYCLE_PS  = 55000,
  parameter int T_ACC_PS    = 55000,
  parameter int T_OEACC_PS  = 25000,
  parameter int T_ASU_PS    = 0,
  parameter int T_PW_PS     = 40000,
  parameter int T_SELSU_PS  = 40000,
  parameter int T_LANESU_PS = 45000,
  parameter int T_DSU_PS    = 25000,
  parameter int T_RELEASE_PS = 20000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [15:0]       req_wdata,
  input  logic [1:0]        req_mask,
  output logic              rsp_valid,
  output logic [15:0]       rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_sel_n,
  output logic              mem_sel_p,
  output logic              mem_outen_n,
  output logic              mem_wren_n,
  output logic              mem_blo_n,
  output logic              mem_bhi_n,
  output logic [15:0]       mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [15:0]       mem_dq_in
);
  localparam int RD_CYC   = read_clocks(T_ACC_PS, T_OEACC_PS, T_CYCLE_PS, CLK_PS);
  localparam int SU_CYC   = clocks_for(T_ASU_PS, CLK_PS);
  localparam int PW_CYC   = pulse_clocks(T_PW_PS, T_DSU_PS, T_SELSU_PS, T_LANESU_PS,
                                         SU_CYC, CLK_PS);
  localparam int REC_CYC  = recovery_clocks(T_CYCLE_PS, SU_CYC, PW_CYC, CLK_PS);
  localparam int TURN_CYC = clocks_for(T_RELEASE_PS, CLK_PS);

  logic bus_free;
  logic cap_now;

  asram_seq #(
    .ADDR_W (ADDR_W),
    .RD_CYC (RD_CYC),
    .SU_CYC (SU_CYC),
    .PW_CYC (PW_CYC),
    .REC_CYC(REC_CYC)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .req_mask   (req_mask),
    .bus_free   (bus_free),
    .req_ready  (req_ready),
    .cap_now    (cap_now),
    .mem_addr   (mem_addr),
    .mem_sel_n  (mem_sel_n),
    .mem_sel_p  (mem_sel_p),
    .mem_outen_n(mem_outen_n),
    .mem_wren_n (mem_wren_n),
    .mem_blo_n  (mem_blo_n),
    .mem_bhi_n  (mem_bhi_n),
    .mem_dq_out (mem_dq_out),
    .mem_dq_oe  (mem_dq_oe)
  );

  asram_bus_guard #(.TURN_CYC(TURN_CYC)) u_guard (
    .clk        (clk),
    .rst_n      (rst_n),
    .mem_outen_n(mem_outen_n),
    .mem_dq_oe  (mem_dq_oe),
    .bus_free   (bus_free)
  );

  asram_rd_path u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_now  (cap_now),
    .mem_dq_in(mem_dq_in),
    .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata)
  );

endmodule

// File: tb/asram_ctrl_bench.sv
`timescale 1ns/1ps
module asram_ctrl_bench;
  localparam int AW = 12;
  localparam int TCLK = 4;
  localparam int EXP_LAT = (55 + TCLK - 1) / TCLK;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0] req_mask = '0;
  logic req_ready, rsp_valid;
  logic [15:0] rsp_rdata;
  logic [AW-1:0] mem_addr;
  logic mem_sel_n, mem_sel_p, mem_outen_n, mem_wren_n, mem_blo_n, mem_bhi_n, mem_dq_oe;
  logic [15:0] mem_dq_out;
  logic [15:0] mem_dq_in = '0;

  asram_ctrl #(.ADDR_W(AW)) u_asram_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_mask(req_mask), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_sel_n(mem_sel_n), .mem_sel_p(mem_sel_p),
    .mem_outen_n(mem_outen_n), .mem_wren_n(mem_wren_n), .mem_blo_n(mem_blo_n),
    .mem_bhi_n(mem_bhi_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in));

  always #2 clk = ~clk;

  int total = 0, bad = 0, cyc = 0;
  bit armed = 1'b0, finished = 1'b0;
  int sel_rises = 0, we_falls = 0;
  real t_addr = -1000.0, t_sel = -1000.0, t_oe_fall = -1000.0, t_oe_rise = -1000.0;
  real t_lane = -1000.0, t_data = -1000.0, t_we_fall = -1000.0;
  logic [15:0] sram [int];
  logic [15:0] ref_mem [int];
  logic [15:0] exp_q [$];
  int acc_q [$];
  wire sel_w = !mem_sel_n && mem_sel_p;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] rd_word(input logic [15:0] m [int], input int a);
    return m.exists(a) ? m[a] : 16'h0000;
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // Memory model: a word appears only once access, select and OE delays are met.
  initial begin
    #0.5;
    forever begin
      logic [15:0] v;
      v = rd_word(sram, int'(mem_addr));
      if (sel_w && !mem_outen_n && ($realtime - t_addr >= 55.0) &&
          ($realtime - t_sel >= 55.0) && ($realtime - t_oe_fall >= 25.0))
        mem_dq_in = v;
      else
        mem_dq_in = ~v ^ 16'h5A5A;
      #1;
    end
  end

  always @(mem_addr) t_addr = $realtime;
  always @(negedge mem_outen_n) t_oe_fall = $realtime;
  always @(posedge mem_outen_n) t_oe_rise = $realtime;
  always @(mem_blo_n or mem_bhi_n) t_lane = $realtime;
  always @(mem_dq_out or mem_dq_oe) t_data = $realtime;
  always @(posedge sel_w) begin
    if (armed) begin
      chk($realtime - t_sel >= 55.0, "R4 access start spacing", 32'($rtoi($realtime - t_sel)), 32'd55);
      sel_rises++;
    end
    t_sel = $realtime;
  end
  always @(negedge mem_wren_n) begin
    t_we_fall = $realtime;
    if (armed) we_falls++;
  end
  always @(mem_blo_n or mem_bhi_n or sel_w or mem_addr)
    if (armed && !mem_wren_n) chk(1'b0, "R5 strobe moved during write", 32'd1, 32'd0);

  // Write ends on write-enable rise: check setups, then store enabled lanes.
  always @(posedge mem_wren_n) begin
    if (armed) begin
      chk(sel_w && !(mem_blo_n && mem_bhi_n), "R5 select/lane at write end", {30'd0, mem_blo_n, mem_bhi_n}, 32'd0);
      chk($realtime - t_we_fall >= 40.0, "R5 write pulse width", 32'($rtoi($realtime - t_we_fall)), 32'd40);
      chk($realtime - t_sel >= 40.0 && $realtime - t_addr >= 40.0, "R5 select/address setup",
          32'($rtoi($realtime - t_sel)), 32'd40);
      chk($realtime - t_lane >= 45.0, "R5 lane setup", 32'($rtoi($realtime - t_lane)), 32'd45);
      chk(mem_dq_oe && $realtime - t_data >= 25.0, "R5 data setup", 32'($rtoi($realtime - t_data)), 32'd25);
      begin
        logic [15:0] w;
        w = rd_word(sram, int'(mem_addr));
        if (!mem_blo_n) w[7:0] = mem_dq_out[7:0];
        if (!mem_bhi_n) w[15:8] = mem_dq_out[15:8];
        sram[int'(mem_addr)] = w;
      end
    end
  end

  always @(posedge clk) cyc <= cyc + 1;

  // Per-clock comparison against the bench's own view.
  always @(negedge clk) begin
    if (armed) begin
      chk(mem_sel_n == !mem_sel_p, "R2 select polarity", {30'd0, mem_sel_n, mem_sel_p}, 32'b10);
      chk(req_ready == !sel_w, "R9 ready vs busy", {31'd0, req_ready}, {31'd0, !sel_w});
      if (mem_dq_oe)
        chk(mem_outen_n && ($realtime - t_oe_rise >= 20.0), "R8 driver turn-on gap",
            32'($rtoi($realtime - t_oe_rise)), 32'd20);
      if (!mem_wren_n) chk(mem_outen_n, "R8 output enable during write", {31'd0, mem_outen_n}, 32'd1);
      if (!mem_outen_n)
        chk(!mem_blo_n && !mem_bhi_n, "R3 read lanes", {30'd0, mem_blo_n, mem_bhi_n}, 32'd0);
      if (rsp_valid) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R3 unexpected response", 32'd1, 32'd0);
        end else begin
          logic [15:0] e;
          int a;
          e = exp_q.pop_front();
          a = acc_q.pop_front();
          chk(rsp_rdata == e, "R3 read data", {16'd0, rsp_rdata}, {16'd0, e});
          chk(cyc - a == EXP_LAT, "R3 read latency", 32'(cyc - a), 32'(EXP_LAT));
        end
      end
    end
  end

  task automatic issue(input bit w, input int a, input logic [15:0] d, input logic [1:0] m);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = AW'(a); req_wdata = d; req_mask = m;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (w) begin
      logic [15:0] r;
      r = rd_word(ref_mem, a);
      if (m[0]) r[7:0] = d[7:0];   // R6 low byte lane
      if (m[1]) r[15:8] = d[15:8]; // R6 high byte lane
      ref_mem[a] = r;
    end else begin
      exp_q.push_back(rd_word(ref_mem, a));
      acc_q.push_back(cyc);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog expired", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 state during and after reset
    chk(mem_sel_n && !mem_sel_p && mem_outen_n && mem_wren_n, "R1 strobes in reset",
        {28'd0, mem_sel_n, mem_sel_p, mem_outen_n, mem_wren_n}, 32'hB);
    chk(mem_blo_n && mem_bhi_n && !mem_dq_oe && !rsp_valid, "R1 lanes/driver in reset",
        {28'd0, mem_blo_n, mem_bhi_n, mem_dq_oe, rsp_valid}, 32'hC);
    rst_n = 1'b1;
    armed = 1'b1;
    repeat (3) @(negedge clk);
    chk(req_ready && !sel_w && !mem_dq_oe, "R1 idle after reset", {30'd0, req_ready, sel_w}, 32'b10);

    // R5 R3 full word write and readback
    issue(1, 16, 16'hA5C3, 2'b11);
    issue(0, 16, 16'h0, 2'b11);
    // R6 lane writes
    issue(1, 17, 16'hFFFF, 2'b11);
    issue(1, 17, 16'h1234, 2'b01);
    issue(0, 17, 16'h0, 2'b00);
    issue(1, 17, 16'h9876, 2'b10);
    issue(0, 17, 16'h0, 2'b00);
    // R7 empty-mask write
    begin
      int sr, wf;
      sr = sel_rises; wf = we_falls;
      issue(1, 16, 16'h0000, 2'b00);
      chk(req_ready, "R7 ready after empty write", {31'd0, req_ready}, 32'd1);
      repeat (4) @(negedge clk);
      chk(sel_rises == sr && we_falls == wf, "R7 no strobe for empty write",
          32'(sel_rises - sr + we_falls - wf), 32'd0);
    end
    issue(0, 16, 16'h0, 2'b11);
    // R8 write straight after read, read straight after write
    issue(1, 18, 16'h0F0F, 2'b11);
    issue(0, 18, 16'h0, 2'b11);
    issue(1, 18, 16'hF0F0, 2'b11);
    issue(0, 18, 16'h0, 2'b11);
    // Mixed traffic
    for (int i = 0; i < 120; i++) begin
      issue(1'($urandom_range(0, 1)), int'($urandom_range(0, 31)),
            16'($urandom), 2'($urandom_range(0, 3)));
    end
    for (int a = 0; a < 32; a++) issue(0, a, 16'h0, 2'b11);
    while (exp_q.size() != 0) @(negedge clk);
    repeat (10) @(negedge clk);
    finish_run();
  end

endmodule